// File: doc/BRIEF.md
# Two-Digit Scrolling Phrase Display

This block drives a pair of adjacent seven-segment digits so that a phrase of up to sixteen characters appears to slide across them. Each digit owns a small position counter that selects one entry of a sixteen-entry glyph table. Both counters run from one clock and advance together on a single-cycle tick from a built-in prescaler, which brings the system clock down to a rate a person can read.

A load strobe places the two counters one position apart, the left digit at the first character and the right digit at the second. From then on the right digit always shows the character that the left digit will show next. The phrase length is an input. When a counter reaches the first index past the phrase, that digit's decoder blanks the digit and asserts an active-low clear into its own counter, so the phrase restarts at index zero. The segment buses are active low and go straight to the display.

Top module: `scroll_disp_top`

## Requirements
- R1: While `rst_n` is low, both position counters are held at index 0 without waiting for a clock edge, so with `phrase_len` of 16 both digits show glyph 0 (bus value 7'h40).
- R2: Segment buses are active low (a lit segment reads 0). Bit 0 is segment A and bit 6 is segment G. The glyph for index n is the hexadecimal digit n: glyph 0 lights every segment but G (7'h40 on the bus), and glyph 1 lights only B and C (7'h79 on the bus).
- R3: The prescaler produces an advance tick on the clock edge that ends every TICK_DIV-th cycle after reset. A counter that is neither cleared nor loaded steps up by one on that edge and holds its value on every other edge.
- R4: When `load_n` is low at a clock edge, the left counter takes index 0 and the right counter takes index 1 on that edge, and this overrides a tick on the same edge.
- R5: After a load, and while both indexes lie inside the phrase, the right digit shows the glyph for the left index plus one, with the right digit wrapping to 0 after the last character.
- R6: An index at or above `phrase_len` blanks its digit (all bus bits 1), and the counter returns to index 0 on the next clock edge. A `phrase_len` of 16 or more never blanks the digit, and index 15 wraps to 0 on a tick.
- R7: The end-of-phrase clear takes priority over `load_n`. A counter that sits past the end while `load_n` is low goes to index 0, not to its load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Load strobe for both counters, active low, sampled on the clock edge |
| phrase_len | input | 5 | Number of characters in the phrase (1 to 16) |
| seg_left_n | output | 7 | Left digit segments A..G in bits 0..6, active low |
| seg_right_n | output | 7 | Right digit segments A..G in bits 0..6, active low |

## Verification
The segment buses are combinational from the counter registers and `phrase_len`. A load or tick therefore shows on the buses in the cycle that follows the edge that samples it, a past-end index blanks the digit in that same cycle, and the clear lands one edge later. The bench keeps a cycle-by-cycle model of the prescaler phase and both indexes. It updates this model on the rising edge and compares both buses against it at every falling edge, and it changes inputs only right after that comparison. The sweep covers every phrase length from 1 to 16, reloads at several tick phases, and also runs a length of 0, a length above 16, and a clear that collides with a held load.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;

   // Active-high glyphs, segment A in bit 0 through segment G in bit 6.
   function automatic seg_t glyph_of(input logic [3:0] code);
      seg_t g;
      case (code)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/scroll_tick_gen.sv
module scroll_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("scroll_tick_gen: DIV must be at least 1");
         assign tick = 1'b0;
      end else if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              phase_q <= '0;
            else if (phase_q == LAST) phase_q <= '0;
            else                     phase_q <= phase_q + 1'b1;
         end

         assign tick = (phase_q == LAST);

         // R3: a tick never lasts two cycles when the divider is above one
         p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/scroll_pos_ctr.sv
module scroll_pos_ctr #(
   parameter int IDX_W = 4,
   parameter int INIT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] INIT_V = IDX_W'(INIT);

   generate
      if (INIT < 0 || INIT >= (1 << IDX_W)) begin : g_bad_init
         $error("scroll_pos_ctr: INIT out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (!clr_n)  idx <= '0;
      else if (!load_n) idx <= INIT_V;
      else if (adv)     idx <= idx + 1'b1;
   end

   // R6 / R7: clear from the decoder wins over everything
   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> idx == '0);
   // R4: load reaches the counter when no clear is pending
   p_load_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !load_n) |=> idx == INIT_V);
   // R3: single step on a tick
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && adv) |=> idx == IDX_W'($past(idx) + 1'b1));
   // R3: hold between ticks
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && !adv) |=> $stable(idx));
endmodule

// File: rtl/scroll_glyph_dec.sv
module scroll_glyph_dec
   import scroll_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W:0]   len,
   output seg_t             seg_n,
   output logic             clr_n
);
   logic past_end;

   assign past_end = ({1'b0, idx} >= len);
   assign clr_n    = !past_end;
   assign seg_n    = past_end ? '1 : ~glyph_of(4'(idx));
endmodule

// File: rtl/scroll_disp_top.sv
module scroll_disp_top
   import scroll_pkg::*;
#(
   parameter int TICK_DIV = 6_250_000,
   parameter int IDX_W    = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_n,
   input  logic [4:0]   phrase_len,
   output logic [6:0]   seg_left_n,
   output logic [6:0]   seg_right_n
);
   localparam int NUM_DIG = 2;
   localparam int LEN_W   = IDX_W + 1;

   generate
      if (IDX_W < 1 || IDX_W > 4) begin : g_bad_w
         $error("scroll_disp_top: IDX_W must be 1..4");
      end
   endgenerate

   logic             tick;
   logic [LEN_W-1:0] len_v;
   logic [IDX_W-1:0] idx_arr [NUM_DIG];
   logic             clr_arr [NUM_DIG];
   seg_t             seg_arr [NUM_DIG];

   // Lengths beyond the index range act as a full-length phrase.
   assign len_v = (phrase_len > 5'(1 << IDX_W)) ? LEN_W'(1 << IDX_W)
                                                : LEN_W'(phrase_len);

   scroll_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
      scroll_pos_ctr #(.IDX_W(IDX_W), .INIT(g)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_n  (clr_arr[g]),
         .load_n (load_n),
         .adv    (tick),
         .idx    (idx_arr[g])
      );
      scroll_glyph_dec #(.IDX_W(IDX_W)) u_dec (
         .idx   (idx_arr[g]),
         .len   (len_v),
         .seg_n (seg_arr[g]),
         .clr_n (clr_arr[g])
      );
   end

   assign seg_left_n  = seg_arr[0];
   assign seg_right_n = seg_arr[1];

   // R5: a clean load leaves the right digit one position ahead
   p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && clr_arr[0] && clr_arr[1]) |=> idx_arr[1] == IDX_W'(idx_arr[0] + 1'b1));
   // R4: both counters load on the same edge
   p_joint_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && clr_arr[0] && clr_arr[1]) |=> (idx_arr[0] == '0));
endmodule

// File: tb/scroll_disp_top_tb_top.sv
module scroll_disp_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_n = 1'b1;
   logic [4:0] phrase_len = 5'd16;
   logic [6:0] seg_left_n, seg_right_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model state
   int m_ph = 0, m_l = 0, m_r = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   scroll_disp_top #(.TICK_DIV(DIV), .IDX_W(4)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_n      (load_n),
      .phrase_len  (phrase_len),
      .seg_left_n  (seg_left_n),
      .seg_right_n (seg_right_n)
   );

   function automatic logic [6:0] ref_glyph(input int n);
      case (n)
         0: return 7'h3F;   1: return 7'h06;   2: return 7'h5B;   3: return 7'h4F;
         4: return 7'h66;   5: return 7'h6D;   6: return 7'h7D;   7: return 7'h07;
         8: return 7'h7F;   9: return 7'h6F;  10: return 7'h77;  11: return 7'h7C;
        12: return 7'h39;  13: return 7'h5E;  14: return 7'h79;  default: return 7'h71;
      endcase
   endfunction

   function automatic int eff_len();
      return (phrase_len > 5'd16) ? 16 : int'(phrase_len);
   endfunction

   function automatic logic [6:0] ref_bus(input int n);
      if (n >= eff_len()) return 7'h7F;
      return ~ref_glyph(n);
   endfunction

   // R3/R4/R6/R7 reference behaviour, one update per rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_l <= 0; m_r <= 0;
      end else begin
         bit t;
         t = (m_ph == DIV - 1);
         m_ph <= t ? 0 : m_ph + 1;
         if (m_l >= eff_len())   m_l <= 0;
         else if (!load_n)       m_l <= 0;
         else if (t)             m_l <= (m_l + 1) % 16;
         if (m_r >= eff_len())   m_r <= 0;
         else if (!load_n)       m_r <= 1;
         else if (t)             m_r <= (m_r + 1) % 16;
      end
   end

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle, then compare both buses with the model at the falling edge
   task automatic cyc();
      @(negedge clk);
      if (m_l >= eff_len()) check("R6 left blank", seg_left_n, ref_bus(m_l));
      else                  check("R3 left", seg_left_n, ref_bus(m_l));
      if (m_r >= eff_len()) check("R6 right blank", seg_right_n, ref_bus(m_r));
      else                  check("R5 right", seg_right_n, ref_bus(m_r));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      cyc();
      load_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 3 + 2);
      check("R1 left reset", seg_left_n, 7'h40);
      check("R1 right reset", seg_right_n, 7'h40);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 / R2: load places glyph 0 left and glyph 1 right
      pulse_load();
      check("R4 left load", seg_left_n, 7'h40);
      check("R2 right glyph 1", seg_right_n, 7'h79);

      // full sweep of lengths with reloads at differing tick phases
      for (int len = 1; len <= 16; len++) begin
         phrase_len = 5'(len);
         run(2);
         pulse_load();
         run(len * DIV * 2 + 3);
         pulse_load();
         run(len + 1);
         pulse_load();
         run(len * DIV + 2);
      end

      // R6: lengths of 0 and above 16
      phrase_len = 5'd0;
      run(4);
      check("R6 zero length blank", seg_left_n, 7'h7F);
      phrase_len = 5'd20;
      pulse_load();
      run(16 * DIV * 2 + 2);

      // R7: right counter loaded past the end, load held for a second edge
      phrase_len = 5'd1;
      run(2);
      load_n = 1'b0;
      cyc();
      check("R7 right blank after load", seg_right_n, 7'h7F);
      cyc();
      check("R7 clear beats load", seg_right_n, 7'h40);
      load_n = 1'b1;
      run(DIV * 3);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule